// File: doc/BRIEF.md
# Byte-Wide Data Memory with Pointer Indirection

This block is the data memory of a small 8-bit controller core. It spans a 7-bit address space of 128 byte locations. The space is split into regions. One location is virtual: it redirects to whatever address a 7-bit pointer register holds. The pointer sits at the next address. A window of special-register addresses is passed out to peripherals on an external port. A reserved stretch reads as zero and ignores writes. The upper half is general-purpose RAM.

The core reads through a combinational port with its own address. It updates through a synchronous port that performs either a byte write or a single-bit set or clear. The bit operation is a read-modify-write finished within one clock. Both ports resolve the virtual location through the pointer before anything else is decoded. When the pointer itself holds the virtual address, the access is suppressed.

Top module: `dmem_space`

## Requirements
- R1: After reset the pointer holds 00H. A read of address 01H then returns 80H, and a read of address 00H returns 00H.
- R2: A read of address 01H returns the stored 7-bit pointer in bits 6:0 and a 1 in bit 7.
- R3: A byte write to address 01H stores only bits 6:0 of the write data into the pointer.
- R4: A read or write at address 00H acts on the address held in the pointer, with the same region decoding as a direct access.
- R5: When the pointer holds 00H, a read at address 00H returns 00H, and a write or bit operation at 00H changes nothing: there is no external strobe and no RAM or pointer update.
- R6: Addresses 24H to 3FH read 00H. Writes and bit operations there change nothing and raise no external strobe.
- R7: Addresses 40H to 7FH are 64 bytes of RAM. A value written at a clock edge appears on the read port once that edge has passed. Reads are combinational.
- R8: Addresses 02H to 23H are forwarded. A read returns sfr_rd_data_i, with the resolved address on sfr_rd_addr_o. A write raises sfr_we_o for one cycle, with the resolved address on sfr_wr_addr_o and the byte on sfr_wr_data_o.
- R9: With bit_en_i high and wr_en_i low, the bit at wr_addr_i chosen by bit_idx_i (0 = LSB) is set when bit_set_i is 1 and cleared when it is 0. The other seven bits keep their value. The target is resolved through the pointer like a byte write.
- R10: When wr_en_i and bit_en_i are both high, the byte write is performed and the bit request is ignored.
- R11: A bit operation on the pointer works on its read value (bit 7 = 1) and stores bits 6:0. Setting or clearing bit 7 therefore leaves the pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rd_addr_i | input | 7 | Read address |
| rd_data_o | output | 8 | Combinational read data |
| wr_addr_i | input | 7 | Target address for a byte write or bit operation |
| wr_data_i | input | 8 | Byte write data |
| wr_en_i | input | 1 | Byte write request |
| bit_en_i | input | 1 | Bit set/clear request |
| bit_set_i | input | 1 | 1 = set, 0 = clear |
| bit_idx_i | input | 3 | Bit index, 0 = LSB |
| sfr_rd_addr_o | output | 7 | Resolved read address toward the peripherals |
| sfr_rd_data_i | input | 8 | Peripheral byte at sfr_rd_addr_o |
| sfr_wr_addr_o | output | 7 | Resolved write target toward the peripherals |
| sfr_cur_i | input | 8 | Peripheral byte at sfr_wr_addr_o, used for bit operations |
| sfr_wr_data_o | output | 8 | Byte to store in the peripheral |
| sfr_we_o | output | 1 | Peripheral write strobe |

## Verification
Read data and the peripheral strobe, address and data are combinational. The bench therefore drives each operation on the falling edge and samples these outputs one nanosecond later, comparing them against a model state that has not yet taken the coming rising edge. Storage results (RAM, pointer, forwarded register) are due exactly one rising edge later. The model commits its own update after that edge, so the next operation's read check sees them. Reset release passes through a two-stage synchronizer, so the first checks come three edges after rst_ni rises.

// File: rtl/dmem_pkg.sv
package dmem_pkg;
  localparam int unsigned DMEM_AW       = 7;
  localparam int unsigned DMEM_DW       = 8;
  localparam int unsigned DMEM_IND_ADDR = 0;
  localparam int unsigned DMEM_PTR_ADDR = 1;
  localparam int unsigned DMEM_SFR_LAST = 35;
  localparam int unsigned DMEM_RAM_BASE = 64;

  typedef enum logic [2:0] {
    RG_SELF = 3'd0,
    RG_PTR  = 3'd1,
    RG_SFR  = 3'd2,
    RG_VOID = 3'd3,
    RG_RAM  = 3'd4
  } region_e;
endpackage

// File: rtl/dmem_rst_sync.sv
module dmem_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/dmem_addr_resolve.sv
module dmem_addr_resolve
  import dmem_pkg::*;
#(
  parameter int unsigned AW       = DMEM_AW,
  parameter int unsigned IND_ADDR = DMEM_IND_ADDR,
  parameter int unsigned PTR_ADDR = DMEM_PTR_ADDR,
  parameter int unsigned SFR_LAST = DMEM_SFR_LAST,
  parameter int unsigned RAM_BASE = DMEM_RAM_BASE
) (
  input  logic [AW-1:0] addr_i,
  input  logic [AW-1:0] ptr_i,
  output logic [AW-1:0] res_o,
  output region_e       region_o
);
  always_comb begin
    res_o = (addr_i == AW'(IND_ADDR)) ? ptr_i : addr_i;
    if (res_o == AW'(IND_ADDR))       region_o = RG_SELF;
    else if (res_o == AW'(PTR_ADDR))  region_o = RG_PTR;
    else if (res_o <= AW'(SFR_LAST))  region_o = RG_SFR;
    else if (res_o >= AW'(RAM_BASE))  region_o = RG_RAM;
    else                              region_o = RG_VOID;
  end
endmodule

// File: rtl/dmem_ram.sv
module dmem_ram #(
  parameter int unsigned DW    = 8,
  parameter int unsigned DEPTH = 64,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          we_i,
  input  logic [IW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [IW-1:0] raddr_a_i,
  output logic [DW-1:0] rdata_a_o,
  input  logic [IW-1:0] raddr_b_i,
  output logic [DW-1:0] rdata_b_o
);
  logic [DW-1:0] cells_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) cells_q[waddr_i] <= wdata_i;
  end

  assign rdata_a_o = cells_q[raddr_a_i];
  assign rdata_b_o = cells_q[raddr_b_i];
endmodule

// File: rtl/dmem_bit_merge.sv
module dmem_bit_merge #(
  parameter int unsigned DW = 8,
  localparam int unsigned BW = $clog2(DW)
) (
  input  logic [DW-1:0] cur_i,
  input  logic [DW-1:0] byte_i,
  input  logic          byte_en_i,
  input  logic          bit_set_i,
  input  logic [BW-1:0] bit_idx_i,
  output logic [DW-1:0] val_o
);
  logic [DW-1:0] mask;

  always_comb begin
    mask = '0;
    mask[bit_idx_i] = 1'b1;
    if (byte_en_i)      val_o = byte_i;
    else if (bit_set_i) val_o = cur_i | mask;
    else                val_o = cur_i & ~mask;
  end
endmodule

// File: rtl/dmem_space.sv
module dmem_space
  import dmem_pkg::*;
#(
  parameter int unsigned AW       = DMEM_AW,
  parameter int unsigned DW       = DMEM_DW,
  parameter int unsigned SFR_LAST = DMEM_SFR_LAST,
  parameter int unsigned RAM_BASE = DMEM_RAM_BASE,
  localparam int unsigned BW      = $clog2(DW),
  localparam int unsigned DEPTH   = (1 << AW) - RAM_BASE,
  localparam int unsigned RIW     = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic          wr_en_i,
  input  logic          bit_en_i,
  input  logic          bit_set_i,
  input  logic [BW-1:0] bit_idx_i,
  output logic [AW-1:0] sfr_rd_addr_o,
  input  logic [DW-1:0] sfr_rd_data_i,
  output logic [AW-1:0] sfr_wr_addr_o,
  input  logic [DW-1:0] sfr_cur_i,
  output logic [DW-1:0] sfr_wr_data_o,
  output logic          sfr_we_o
);
  logic          rst_n;
  logic [AW-1:0] ptr_q, ptr_d;
  logic          ptr_we;
  logic [AW-1:0] rd_res, wr_res;
  region_e       rd_reg, wr_reg;
  logic [AW-1:0] rd_off, wr_off;
  logic [DW-1:0] ram_rd, ram_cur;
  logic [DW-1:0] wr_cur, wr_val;
  logic          op_req, ram_we;

  function automatic logic [DW-1:0] pick(input region_e rg, input logic [AW-1:0] p,
                                         input logic [DW-1:0] ram_v, input logic [DW-1:0] sfr_v);
    logic [DW-1:0] v;
    case (rg)
      RG_PTR:  v = {1'b1, {(DW-AW-1){1'b0}}, p};
      RG_SFR:  v = sfr_v;
      RG_RAM:  v = ram_v;
      default: v = '0;
    endcase
    return v;
  endfunction

  dmem_rst_sync #(.STAGES(2)) rst_sync_i (
    .clk_i (clk_i), .rst_ni (rst_ni), .rst_no (rst_n)
  );

  dmem_addr_resolve #(.AW(AW), .SFR_LAST(SFR_LAST), .RAM_BASE(RAM_BASE)) rd_dec_i (
    .addr_i (rd_addr_i), .ptr_i (ptr_q), .res_o (rd_res), .region_o (rd_reg)
  );

  dmem_addr_resolve #(.AW(AW), .SFR_LAST(SFR_LAST), .RAM_BASE(RAM_BASE)) wr_dec_i (
    .addr_i (wr_addr_i), .ptr_i (ptr_q), .res_o (wr_res), .region_o (wr_reg)
  );

  assign rd_off = rd_res - AW'(RAM_BASE);
  assign wr_off = wr_res - AW'(RAM_BASE);

  dmem_ram #(.DW(DW), .DEPTH(DEPTH)) ram_i (
    .clk_i     (clk_i),
    .we_i      (ram_we),
    .waddr_i   (wr_off[RIW-1:0]),
    .wdata_i   (wr_val),
    .raddr_a_i (rd_off[RIW-1:0]),
    .rdata_a_o (ram_rd),
    .raddr_b_i (wr_off[RIW-1:0]),
    .rdata_b_o (ram_cur)
  );

  // Read path
  assign sfr_rd_addr_o = rd_res;
  assign rd_data_o     = pick(rd_reg, ptr_q, ram_rd, sfr_rd_data_i);

  // Write path: current value of the resolved target feeds the bit merge
  assign wr_cur = pick(wr_reg, ptr_q, ram_cur, sfr_cur_i);

  dmem_bit_merge #(.DW(DW)) merge_i (
    .cur_i     (wr_cur),
    .byte_i    (wr_data_i),
    .byte_en_i (wr_en_i),
    .bit_set_i (bit_set_i),
    .bit_idx_i (bit_idx_i),
    .val_o     (wr_val)
  );

  assign op_req        = wr_en_i | bit_en_i;
  assign ram_we        = op_req & (wr_reg == RG_RAM);
  assign ptr_we        = op_req & (wr_reg == RG_PTR);
  assign sfr_we_o      = op_req & (wr_reg == RG_SFR);
  assign sfr_wr_addr_o = wr_res;
  assign sfr_wr_data_o = wr_val;

  // Pointer register: next state and register kept apart
  always_comb begin
    ptr_d = ptr_q;
    if (ptr_we) ptr_d = wr_val[AW-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) ptr_q <= '0;
    else        ptr_q <= ptr_d;
  end

  // R2: pointer reads always carry a 1 in the top bit
  a_r2_ptr_msb: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_addr_i == AW'(DMEM_PTR_ADDR)) |-> rd_data_o[DW-1]);

  // R3: byte write to the pointer keeps the low bits of the data
  a_r3_ptr_low_bits: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_en_i && wr_reg == RG_PTR) |=> (ptr_q == $past(wr_data_i[AW-1:0])));

  // R5: self-referencing indirect read yields zero
  a_r5_self_read_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_addr_i == '0 && ptr_q == '0) |-> (rd_data_o == '0));

  // R5: self-referencing indirect write touches nothing
  a_r5_self_write_none: assert property (@(posedge clk_i) disable iff (!rst_n)
    (wr_addr_i == '0 && ptr_q == '0) |-> (!sfr_we_o && !ram_we) ##1 $stable(ptr_q));

  // R6: reserved window reads zero
  a_r6_void_read_zero: assert property (@(posedge clk_i) disable iff (!rst_n)
    (rd_res > AW'(SFR_LAST) && rd_res < AW'(RAM_BASE)) |-> (rd_data_o == '0));

  // R8: peripheral strobe only inside the forwarded window
  a_r8_strobe_window: assert property (@(posedge clk_i) disable iff (!rst_n)
    sfr_we_o |-> (sfr_wr_addr_o > AW'(DMEM_PTR_ADDR) && sfr_wr_addr_o <= AW'(SFR_LAST)));

  // R11: pointer holds when no update is requested
  a_r11_ptr_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_n)
    !(wr_en_i || bit_en_i) |=> $stable(ptr_q));
endmodule

// File: tb/dmem_space_tb.sv
module dmem_space_tb_top;
  logic       clk;
  logic       rst_n;
  logic [6:0] rd_addr, wr_addr;
  logic [7:0] rd_data, wr_data;
  logic       wr_en, bit_en, bit_set;
  logic [2:0] bit_idx;
  logic [6:0] sfr_rd_addr, sfr_wr_addr;
  logic [7:0] sfr_rd_data, sfr_cur, sfr_wr_data;
  logic       sfr_we;

  logic [7:0] mem_m  [64];
  logic [7:0] sfr_m  [34];
  logic [6:0] ptr_m;
  int compared;
  int mismatched;
  bit done;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  assign sfr_rd_data = (sfr_rd_addr >= 7'd2 && sfr_rd_addr <= 7'd35) ? sfr_m[int'(sfr_rd_addr) - 2] : 8'h00;
  assign sfr_cur     = (sfr_wr_addr >= 7'd2 && sfr_wr_addr <= 7'd35) ? sfr_m[int'(sfr_wr_addr) - 2] : 8'h00;

  dmem_space dut_i (
    .clk_i (clk), .rst_ni (rst_n),
    .rd_addr_i (rd_addr), .rd_data_o (rd_data),
    .wr_addr_i (wr_addr), .wr_data_i (wr_data), .wr_en_i (wr_en),
    .bit_en_i (bit_en), .bit_set_i (bit_set), .bit_idx_i (bit_idx),
    .sfr_rd_addr_o (sfr_rd_addr), .sfr_rd_data_i (sfr_rd_data),
    .sfr_wr_addr_o (sfr_wr_addr), .sfr_cur_i (sfr_cur),
    .sfr_wr_data_o (sfr_wr_data), .sfr_we_o (sfr_we)
  );

  function automatic logic [6:0] resolve(input logic [6:0] a);
    return (a == 7'd0) ? ptr_m : a;
  endfunction

  function automatic logic [7:0] value_at(input logic [6:0] r);
    if (r == 7'd0)        return 8'h00;
    else if (r == 7'd1)   return {1'b1, ptr_m};
    else if (r <= 7'd35)  return sfr_m[int'(r) - 2];
    else if (r < 7'd64)   return 8'h00;
    else                  return mem_m[int'(r) - 64];
  endfunction

  function automatic string area_tag(input logic [6:0] a);
    logic [6:0] r;
    r = resolve(a);
    if (r == 7'd0)       return "R5";
    else if (r == 7'd1)  return "R2";
    else if (r <= 7'd35) return "R8";
    else if (r < 7'd64)  return "R6";
    else if (a == 7'd0)  return "R4";
    else                 return "R7";
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic step(input logic [6:0] wa, input logic [7:0] wd, input logic we,
                      input logic be, input logic bs, input logic [2:0] bi,
                      input logic [6:0] ra, input string tag);
    logic [6:0] r;
    logic [7:0] cur, nv;
    logic       doit, exp_we;
    string      t;
    @(negedge clk);
    wr_addr = wa; wr_data = wd; wr_en = we; bit_en = be; bit_set = bs; bit_idx = bi;
    rd_addr = ra;
    #1;
    t = (tag.len() != 0) ? tag : area_tag(ra);
    check(t, rd_data, value_at(resolve(ra)));
    r    = resolve(wa);
    doit = (we || be) && (r != 7'd0);
    cur  = value_at(r);
    if (we)      nv = wd;
    else if (bs) nv = cur | (8'h01 << bi);
    else         nv = cur & ~(8'h01 << bi);
    exp_we = doit && r >= 7'd2 && r <= 7'd35;
    check("R8 strobe", {7'd0, sfr_we}, {7'd0, exp_we});
    if (exp_we) begin
      check("R8 addr", {1'b0, sfr_wr_addr}, {1'b0, r});
      check("R8 data", sfr_wr_data, nv);
    end
    @(posedge clk);
    if (doit) begin
      if (r == 7'd1)        ptr_m = nv[6:0];
      else if (r <= 7'd35)  sfr_m[int'(r) - 2] = nv;
      else if (r >= 7'd64)  mem_m[int'(r) - 64] = nv;
    end
  endtask

  task automatic idle_read(input logic [6:0] ra, input string tag);
    step(7'd0, 8'h00, 1'b0, 1'b0, 1'b0, 3'd0, ra, tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual running expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    compared = 0; mismatched = 0; done = 1'b0;
    void'($urandom(32'd2718));
    for (int i = 0; i < 34; i++) sfr_m[i] = 8'(i * 7 + 3);
    for (int i = 0; i < 64; i++) mem_m[i] = 8'h00;
    ptr_m = 7'd0;
    rd_addr = 7'd1; wr_addr = 7'd0; wr_data = 8'h00;
    wr_en = 1'b0; bit_en = 1'b0; bit_set = 1'b0; bit_idx = 3'd0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);

    // R1: reset values seen at the read port
    idle_read(7'd1, "R1 ptr after reset");
    idle_read(7'd0, "R1 indirect after reset");

    // R7: fill RAM so nothing is read before written
    for (int i = 64; i < 128; i++) step(7'(i), 8'(i) ^ 8'hA5, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, "R2");
    idle_read(7'h40, "R7 first ram byte");
    idle_read(7'h7F, "R7 last ram byte");

    // R3: only low 7 bits stored
    step(7'd1, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, "R2");
    idle_read(7'd1, "R3 ptr FF");
    step(7'd1, 8'h80, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, "R2");
    idle_read(7'd1, "R3 ptr 80");

    // R4: indirect write and read
    step(7'd1, 8'h45, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, "R2");
    step(7'd0, 8'h3C, 1'b1, 1'b0, 1'b0, 3'd0, 7'd0, "R4 before");
    idle_read(7'd0,  "R4 indirect read");
    idle_read(7'h45, "R4 direct view");
    step(7'd1, 8'h10, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, "R2");
    step(7'd0, 8'h9A, 1'b1, 1'b0, 1'b0, 3'd0, 7'd0, "R4 sfr via ptr");
    idle_read(7'h10, "R8 sfr direct");

    // R5: self-reference suppressed
    step(7'd1, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, "R2");
    step(7'd0, 8'h77, 1'b1, 1'b0, 1'b0, 3'd0, 7'd0, "R5 write");
    step(7'd0, 8'h00, 1'b0, 1'b1, 1'b1, 3'd3, 7'd0, "R5 bit");
    idle_read(7'd0, "R5 read");
    idle_read(7'd1, "R5 ptr unchanged");

    // R6: reserved window
    step(7'h30, 8'h55, 1'b1, 1'b0, 1'b0, 3'd0, 7'h30, "R6 before");
    idle_read(7'h30, "R6 after write");
    step(7'h24, 8'h00, 1'b0, 1'b1, 1'b1, 3'd0, 7'h3F, "R6 bit");
    idle_read(7'h24, "R6 after bit");

    // R9: bit set and clear on RAM
    step(7'h50, 8'h00, 1'b1, 1'b0, 1'b0, 3'd0, 7'h50, "R7");
    step(7'h50, 8'h00, 1'b0, 1'b1, 1'b1, 3'd7, 7'h50, "R9 pre");
    idle_read(7'h50, "R9 set bit7");
    step(7'h50, 8'hFF, 1'b1, 1'b0, 1'b0, 3'd0, 7'h50, "R7");
    step(7'h50, 8'h00, 1'b0, 1'b1, 1'b0, 3'd2, 7'h50, "R9 pre");
    idle_read(7'h50, "R9 clear bit2");
    step(7'h21, 8'h00, 1'b0, 1'b1, 1'b1, 3'd6, 7'h21, "R9 sfr pre");
    idle_read(7'h21, "R9 sfr bit6");
    step(7'd1, 8'h60, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, "R2");
    step(7'd0, 8'h00, 1'b0, 1'b1, 1'b0, 3'd0, 7'd0, "R9 indirect pre");
    idle_read(7'h60, "R9 indirect clear");

    // R10: byte write wins
    step(7'h51, 8'h0F, 1'b1, 1'b1, 1'b1, 3'd7, 7'h51, "R10 pre");
    idle_read(7'h51, "R10 byte wins");

    // R11: pointer bit ops
    step(7'd1, 8'h12, 1'b1, 1'b0, 1'b0, 3'd0, 7'd1, "R2");
    step(7'd1, 8'h00, 1'b0, 1'b1, 1'b1, 3'd7, 7'd1, "R11 pre");
    idle_read(7'd1, "R11 set bit7");
    step(7'd1, 8'h00, 1'b0, 1'b1, 1'b0, 3'd7, 7'd1, "R11 pre");
    idle_read(7'd1, "R11 clear bit7");
    step(7'd1, 8'h00, 1'b0, 1'b1, 1'b1, 3'd0, 7'd1, "R11 pre");
    idle_read(7'd1, "R11 set bit0");

    // Random mix
    for (int n = 0; n < 5000; n++) begin
      logic [6:0] wa, ra;
      logic [31:0] sel;
      sel = $urandom;
      wa  = (sel[2:0] == 3'd0) ? 7'(sel[3]) : 7'($urandom);
      ra  = (sel[6:4] == 3'd0) ? 7'(sel[7]) : 7'($urandom);
      step(wa, 8'($urandom), sel[8] & sel[9], sel[10] & sel[11], sel[12], 3'(sel[15:13]), ra, "");
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule